// File: doc/BRIEF.md
# Signed Serial-Parallel Multiplier

This block multiplies two two's-complement numbers of `WIDTH` bits and returns their exact `2*WIDTH`-bit product. The multiplicand is held in parallel. The multiplier is consumed one bit per clock, starting from its least significant bit. On each step the block adds the sign-extended multiplicand, or zero, into a running accumulator. The accumulator then shifts right by one place, so the multiplicand never has to move left. The multiplier's top bit has negative weight, so on the final step the multiplicand is subtracted instead of added.

To use the block, pulse `start` while it is idle, with both operands on their inputs. `busy` covers the `WIDTH` arithmetic steps. `done` marks the cycle in which the full product first appears on `product`. The result stays on `product` until the next accepted start.

Top module: `ser_par_mul`

## Requirements
- R1: After reset, `busy` and `done` are low and `product` is zero.
- R2: A `start` sampled high while `busy` is low captures both operands. `busy` is high from the next cycle for exactly `WIDTH` cycles.
- R3: `done` is high for exactly one cycle. That cycle is the first cycle with `busy` low after an operation.
- R4: For operands that are both non-negative, `product` equals their exact product in the `done` cycle.
- R5: For operands with either sign, `product` equals their exact signed product in the `done` cycle. This includes the case where both operands are -2^(WIDTH-1), where the result is +2^(2*WIDTH-2).
- R6: A `start` sampled while `busy` is high is ignored. The running operation keeps its length and its result.
- R7: While idle with no start, `product` holds the last result. Before the first operation, it holds zero.
- R8: A `start` sampled in the `done` cycle begins a new operation at once, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication |
| multiplicandIn | input | WIDTH | Signed multiplicand, sampled with an accepted start |
| multiplierIn | input | WIDTH | Signed multiplier, sampled with an accepted start |
| busy | output | 1 | High while the steps are running |
| done | output | 1 | One-cycle flag: the product is complete |
| product | output | 2*WIDTH | Signed product |

## Verification
Two events can fall in the same cycle. The first case is a result completing while a new start arrives, which the bench provokes by holding `start` high through whole runs. The second case is a start landing during the final, subtracting step, which is provoked the same way. A reference model tracks acceptance and the busy window with plain counters and computes the product as an integer. It compares `busy`, `done` and, whenever idle, `product` on every clock. A start that is wrongly accepted or dropped would therefore show up as a shifted busy window or a wrong result.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic last;
  } spmCtl_t;
endpackage

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output spmCtl_t ctl,
  output logic    busy,
  output logic    done
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LASTSTEP = CW'(WIDTH - 1);

  logic [CW-1:0] stepCnt;

  always_comb begin
    ctl.load = start & ~busy;
    ctl.step = busy;
    ctl.last = busy && (stepCnt == LASTSTEP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else begin
      done <= 1'b0;
      if (ctl.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (busy) begin
        stepCnt <= stepCnt + CW'(1);
        if (ctl.last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2: an unfinished run keeps busy high
  p_busy_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy && !ctl.last |=> busy);
  // R3: the last step leads to done with busy low
  p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.last |=> done && !busy);
  // R3: done lasts a single cycle
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6: a start during a run neither restarts nor stalls the count
  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy && start && !ctl.last |=> busy && (stepCnt == $past(stepCnt) + CW'(1)));
endmodule

// File: rtl/spm_dpath.sv
module spm_dpath
  import spm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  spmCtl_t            ctl,
  input  logic [WIDTH-1:0]   multiplicandIn,
  input  logic [WIDTH-1:0]   multiplierIn,
  output logic [2*WIDTH-1:0] product
);
  localparam int AW = WIDTH + 1;

  logic [WIDTH-1:0] mcand;
  logic [WIDTH-1:0] mplier;
  logic [AW-1:0]    acc;
  logic [WIDTH-1:0] lowBits;
  logic [AW-1:0]    extA;
  logic [AW-1:0]    addend;
  logic [AW-1:0]    sum;

  always_comb begin
    extA = {mcand[WIDTH-1], mcand};
    if (!mplier[0])     addend = '0;
    else if (ctl.last)  addend = ~extA + AW'(1);
    else                addend = extA;
    sum = acc + addend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand   <= '0;
      mplier  <= '0;
      acc     <= '0;
      lowBits <= '0;
    end else if (ctl.load) begin
      mcand   <= multiplicandIn;
      mplier  <= multiplierIn;
      acc     <= '0;
      lowBits <= '0;
    end else if (ctl.step) begin
      acc     <= {sum[AW-1], sum[AW-1:1]};
      lowBits <= {sum[0], lowBits[WIDTH-1:1]};
      mplier  <= {1'b0, mplier[WIDTH-1:1]};
    end
  end

  assign product = {acc[WIDTH-1:0], lowBits};

  // R2: an accepted start clears the partial result
  p_load_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> product == '0);
  // R7: with no load and no step, the result stays put
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load && !ctl.step |=> $stable(product));
endmodule

// File: rtl/ser_par_mul.sv
module ser_par_mul
  import spm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicandIn,
  input  logic [WIDTH-1:0]   multiplierIn,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  spmCtl_t ctl;

  spm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctl(ctl), .busy(busy), .done(done)
  );

  spm_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .multiplicandIn(multiplicandIn), .multiplierIn(multiplierIn),
    .product(product)
  );
endmodule

// File: tb/sim_ser_par_mul.sv
module sim_ser_par_mul;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] aIn = '0;
  logic [W-1:0] bIn = '0;
  logic busy, done;
  logic [2*W-1:0] product;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string busyTag = "R2";

  // reference model state
  logic mBusy = 1'b0;
  logic mDone = 1'b0;
  int   mLeft = 0;
  logic [2*W-1:0] mPend = '0;
  logic [2*W-1:0] mProd = '0;
  logic mNeg = 1'b0, mPendNeg = 1'b0;

  ser_par_mul #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicandIn(aIn), .multiplierIn(bIn),
    .busy(busy), .done(done), .product(product)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rstN) begin
      mDone <= 1'b0;
      if (start && !mBusy) begin
        mBusy    <= 1'b1;
        mLeft    <= W;
        mPend    <= (2*W)'(int'($signed(aIn)) * int'($signed(bIn)));
        mPendNeg <= aIn[W-1] | bIn[W-1];
      end else if (mBusy) begin
        mLeft <= mLeft - 1;
        if (mLeft == 1) begin
          mBusy <= 1'b0;
          mDone <= 1'b1;
          mProd <= mPend;
          mNeg  <= mPendNeg;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (busy !== mBusy) begin
        errors++;
        $display("FAIL %s busy: actual %b expected %b", busyTag, busy, mBusy);
      end
      checks++;
      if (done !== mDone) begin
        errors++;
        $display("FAIL R3 done: actual %b expected %b", done, mDone);
      end
      if (!mBusy) begin
        checks++;
        if (product !== mProd) begin
          errors++;
          $display("FAIL %s product: actual %0d expected %0d",
                   !mDone ? "R7" : (mNeg ? "R5" : "R4"),
                   $signed(product), $signed(mProd));
        end
      end
    end
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic runOne(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    aIn = a; bIn = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; aIn = ~a; bIn = ~b;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || product !== '0) begin
      errors++;
      $display("FAIL R1 reset: actual %b/%b/%0d expected 0/0/0", busy, done, product);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);   // R7: idle product stays zero
    // R4: non-negative operands
    runOne(8'd0, 8'd0);
    runOne(8'd7, 8'd9);
    runOne(8'd127, 8'd127);
    runOne(8'd1, 8'd127);
    // R5: signed corners
    runOne(8'h80, 8'h80);
    runOne(8'h80, 8'h7F);
    runOne(8'h7F, 8'h80);
    runOne(8'hFF, 8'hFF);
    runOne(8'h80, 8'h01);
    runOne(8'hFF, 8'h80);
    runOne(8'h05, 8'hFD);
    // R6: start pulses during a run
    busyTag = "R6";
    @(negedge clk);
    aIn = 8'hC3; bIn = 8'h5A; start = 1'b1;
    @(negedge clk);
    for (int i = 0; i < W; i++) begin
      aIn = 8'(i * 37); bIn = 8'(i * 11 + 3); start = (i % 2 == 0) || (i == W - 1);
      @(negedge clk);
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R8: start held high, back-to-back operations
    busyTag = "R8";
    aIn = 8'h9C; bIn = 8'h81; start = 1'b1;
    for (int i = 0; i < 6 * (W + 1); i++) begin
      @(negedge clk);
      if (done) begin aIn = aIn + 8'd29; bIn = bIn - 8'd13; end
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R5: pseudo-random sweep
    busyTag = "R2";
    for (int n = 0; n < 1500; n++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      runOne(seed[31:24], seed[23:16]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule